// File: doc/BRIEF.md
# CRC-4 Command Framer and Checker

This block guards 16-bit serial balance commands with a 4-bit cyclic redundancy check built on the polynomial x^4 + x + 1. A 16-bit word holds a 12-bit payload in bits 15:4. The low nibble, bits 3:0, holds the bitwise complement of the remainder. That remainder comes from dividing the payload, followed by four zero bits, by the divisor 10011 in modulo-2 arithmetic. A complemented nibble means a word that is all zeros can never pass the check.

Two paths give the same results. The parallel path is pure XOR logic. One half turns a 12-bit payload into a complete framed word. The other half takes a received 16-bit word, complements the low nibble again, divides all 16 bits and reports whether the remainder is zero.

The serial path takes one bit per valid strobe, MSB first. A start pulse opens each frame. The path has a check mode and a generate mode, and it reports its result one cycle after the sixteenth bit is taken.

Top module: `crc4_framer`

## Requirements
- R1: `gen_word[15:4]` always equals `gen_payload`.
- R2: `gen_word[3:0]` is the complement of the remainder of (`gen_payload` followed by 0000) divided by 10011. For example, payload 0xC10 gives 0xC102, payload 0x000 gives 0x000F and payload 0x001 gives 0x001C.
- R3: `rx_ok` is 1 exactly when `rx_word[15:4]`, followed by the complement of `rx_word[3:0]`, leaves a zero remainder when divided by 10011. Every word that R2 produces gives `rx_ok` = 1.
- R4: Flip any single bit of a word that satisfies R3 and `rx_ok` becomes 0.
- R5: `ser_start` clears the serial frame state. Bits are taken MSB first, on cycles where `ser_valid` is 1. `ser_done` is 1 for exactly one cycle: the cycle after the clock edge that took the sixteenth bit.
- R6: When `ser_check` = 0 (generate mode), bits 12 to 15 of a frame are treated as zero. While `ser_done` is 1, `ser_crc` then equals the low nibble that R2 gives for the first 12 bits, for every payload.
- R7: When `ser_check` = 1 (check mode), bits 12 to 15 are complemented before they enter the division. While `ser_done` is 1, `ser_ok` is 1 exactly when the frame satisfies R3.
- R8: A cycle with `ser_valid` = 0 and `ser_start` = 0 does not advance the frame and does not change `ser_crc`.
- R9: Valid bits that arrive after the sixteenth bit and before the next `ser_start` are ignored. They raise no `ser_done` and leave `ser_crc` unchanged.
- R10: After reset, `ser_done` = 0, `ser_crc` = 0xF and `ser_ok` = 1. This is the state with a zero remainder.
- R11: A `ser_start` together with `ser_valid` makes that bit the first bit of a new frame. A `ser_start` in the middle of a frame throws away the partial frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the serial path |
| rst_n | input | 1 | Synchronous reset, active low |
| gen_payload | input | 12 | Payload for the parallel generator |
| gen_word | output | 16 | Framed word: payload and complemented CRC |
| rx_word | input | 16 | Received word for the parallel checker |
| rx_ok | output | 1 | The received word has a valid CRC |
| ser_start | input | 1 | Frame-start pulse for the serial path |
| ser_valid | input | 1 | `ser_bit` is valid this cycle |
| ser_bit | input | 1 | Serial data bit, MSB first |
| ser_check | input | 1 | 1 = check mode, 0 = generate mode |
| ser_done | output | 1 | One-cycle pulse after the sixteenth bit |
| ser_ok | output | 1 | The serial remainder is zero |
| ser_crc | output | 4 | Complement of the serial remainder |

## Verification
The bench compares the serial generator with the parallel generator for all 4096 payloads. It feeds garbage tail bits in generate mode, so a design that did not zero those bits would give wrong CRCs. Single-bit flips in every position of known-good words catch a checker that forgets to complement the received nibble, or that divides only 12 bits. Gapped strobes, extra bits after the frame and restarts in mid-frame expose three faults: a counter that advances without a valid strobe, a remainder that keeps moving past bit sixteen, and a restart that keeps stale state. Each of these shows up as a wrong CRC or a stray `ser_done` pulse.

// File: rtl/crc4_pkg.sv
// Shared constants and the single-bit division step for the CRC-4 block.
// Assumes the polynomial x^4 + x + 1; POLY_TAIL holds its terms below x^4.
package crc4_pkg;
    localparam int CRC_W   = 4;
    localparam int MSG_W   = 12;
    localparam int FRAME_W = MSG_W + CRC_W;
    localparam logic [CRC_W-1:0] POLY_TAIL = 4'b0011;

    // One step of modulo-2 long division: shift in a bit, subtract the divisor if the top bit was set.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] rem,
                                                 input logic din);
        logic [CRC_W-1:0] shifted;
        shifted = {rem[CRC_W-2:0], din};
        return rem[CRC_W-1] ? (shifted ^ POLY_TAIL) : shifted;
    endfunction
endpackage

// File: rtl/crc4_divider.sv
// Combinational modulo-2 divider: one XOR stage per dividend bit, MSB first.
// Assumes the caller has already appended zeros or complemented the tail.
module crc4_divider
    import crc4_pkg::*;
#(
    parameter int DATA_W = FRAME_W
) (
    input  logic [DATA_W-1:0] dividend,
    output logic [CRC_W-1:0]  remainder
);
    logic [CRC_W-1:0] stage [DATA_W+1];

    assign stage[0] = '0;

    // Chain of division steps, one for each bit of the dividend.
    for (genvar g = 0; g < DATA_W; g++) begin : g_step
        assign stage[g+1] = crc_step(stage[g], dividend[DATA_W-1-g]);
    end

    assign remainder = stage[DATA_W];
endmodule

// File: rtl/crc4_serial.sv
// Bit-serial CRC-4 engine. It takes FRAME_W bits MSB first on valid strobes.
// Tail bits are forced to zero in generate mode and complemented in check mode.
// Assumes start may arrive together with the first valid bit.
module crc4_serial
    import crc4_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             valid,
    input  logic             din,
    input  logic             check_mode,
    output logic             done,
    output logic [CRC_W-1:0] rem
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] FULL      = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] LAST      = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] TAIL_FROM = CNT_W'(MSG_W);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] base_cnt;
    logic [CRC_W-1:0] base_rem;
    logic             take;
    logic             eff_bit;

    // Work out the state this cycle starts from, and decide whether the bit is taken.
    always_comb begin
        base_cnt = start ? '0 : cnt;
        base_rem = start ? '0 : rem;
        take     = valid && (base_cnt != FULL);
        eff_bit  = (base_cnt >= TAIL_FROM) ? (check_mode & ~din) : din;
    end

    // Advance the remainder and the bit count; raise done on the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            rem  <= '0;
            done <= 1'b0;
        end else begin
            done <= take && (base_cnt == LAST);
            if (take) begin
                rem <= crc_step(base_rem, eff_bit);
                cnt <= base_cnt + 1'b1;
            end else begin
                rem <= base_rem;
                cnt <= base_cnt;
            end
        end
    end
endmodule

// File: rtl/crc4_framer.sv
// CRC-4 command framer and checker. It has a parallel generator, a parallel
// checker and a bit-serial engine. All three share one division step.
// Assumes the transmitted CRC nibble is the complement of the remainder.
module crc4_framer
    import crc4_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MSG_W-1:0]    gen_payload,
    output logic [FRAME_W-1:0]  gen_word,
    input  logic [FRAME_W-1:0]  rx_word,
    output logic                rx_ok,
    input  logic                ser_start,
    input  logic                ser_valid,
    input  logic                ser_bit,
    input  logic                ser_check,
    output logic                ser_done,
    output logic                ser_ok,
    output logic [CRC_W-1:0]    ser_crc
);
    logic [CRC_W-1:0] gen_rem;
    logic [CRC_W-1:0] chk_rem;
    logic [CRC_W-1:0] ser_rem;

    crc4_divider #(.DATA_W(FRAME_W)) u_gen_div (
        .dividend  ({gen_payload, {CRC_W{1'b0}}}),
        .remainder (gen_rem)
    );

    crc4_divider #(.DATA_W(FRAME_W)) u_chk_div (
        .dividend  ({rx_word[FRAME_W-1:CRC_W], ~rx_word[CRC_W-1:0]}),
        .remainder (chk_rem)
    );

    crc4_serial u_serial (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (ser_start),
        .valid      (ser_valid),
        .din        (ser_bit),
        .check_mode (ser_check),
        .done       (ser_done),
        .rem        (ser_rem)
    );

    // Frame the payload, judge the received word and present the serial result.
    always_comb begin
        gen_word = {gen_payload, ~gen_rem};
        rx_ok    = (chk_rem == '0);
        ser_ok   = (ser_rem == '0);
        ser_crc  = ~ser_rem;
    end
endmodule

// File: rtl/crc4_framer_chk.sv
// Assertion checker for crc4_framer, attached through bind. Ports only.
module crc4_framer_chk
    import crc4_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [FRAME_W-1:0]  gen_word,
    input logic [FRAME_W-1:0]  rx_word,
    input logic                rx_ok,
    input logic                ser_start,
    input logic                ser_valid,
    input logic                ser_done,
    input logic [CRC_W-1:0]    ser_crc
);
    AST_RX_ACCEPTS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word == gen_word) |-> rx_ok); // R3

    AST_SINGLE_FLIP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rx_word ^ gen_word) == 1) |-> !rx_ok); // R4

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ser_done |=> !ser_done); // R5

    AST_NO_DONE_WITHOUT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid |=> !ser_done); // R5

    AST_IDLE_HOLDS_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_valid && !ser_start) |=> $stable(ser_crc)); // R8
endmodule

bind crc4_framer crc4_framer_chk u_framer_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_word  (gen_word),
    .rx_word   (rx_word),
    .rx_ok     (rx_ok),
    .ser_start (ser_start),
    .ser_valid (ser_valid),
    .ser_done  (ser_done),
    .ser_crc   (ser_crc)
);

// File: tb/crc4_framer_tb.sv
// Self-checking bench for crc4_framer: a vector table, then exhaustive and directed tests.
module crc4_framer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    // {payload[11:0], expected framed word[15:0]}, worked out by hand
    localparam logic [27:0] VEC [8] = '{
        {12'h000, 16'h000F}, {12'h001, 16'h001C}, {12'h002, 16'h0029},
        {12'h004, 16'h0043}, {12'h008, 16'h0084}, {12'h010, 16'h010A},
        {12'h003, 16'h003A}, {12'hC10, 16'hC102}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] gen_payload;
    logic [15:0] gen_word;
    logic [15:0] rx_word;
    logic        rx_ok;
    logic        ser_start, ser_valid, ser_bit, ser_check;
    logic        ser_done, ser_ok;
    logic [3:0]  ser_crc;
    int          n_chk = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc4_framer u_dut (
        .clk(clk), .rst_n(rst_n), .gen_payload(gen_payload), .gen_word(gen_word),
        .rx_word(rx_word), .rx_ok(rx_ok), .ser_start(ser_start), .ser_valid(ser_valid),
        .ser_bit(ser_bit), .ser_check(ser_check), .ser_done(ser_done),
        .ser_ok(ser_ok), .ser_crc(ser_crc)
    );

    task automatic check(input bit cond, input string req,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference long division: subtract the shifted divisor under each set leading bit.
    function automatic logic [3:0] ref_rem(input logic [15:0] d);
        logic [15:0] w = d;
        for (int i = 15; i >= 4; i--)
            if (w[i]) w = w ^ (16'h0013 << (i - 4));
        return w[3:0];
    endfunction

    function automatic logic [15:0] ref_word(input logic [11:0] p);
        return {p, ~ref_rem({p, 4'b0000})};
    endfunction

    // Send one 16-bit frame MSB first. Returns at the negedge where done should show.
    task automatic send_frame(input logic [15:0] w, input logic mode, input bit gap);
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            ser_start = (i == 15);
            ser_valid = 1'b1;
            ser_bit   = w[i];
            ser_check = mode;
            if (gap && i != 0) begin
                @(negedge clk);
                ser_start = 1'b0;
                ser_valid = 1'b0;
            end
        end
        @(negedge clk);
        ser_start = 1'b0;
        ser_valid = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; gen_payload = '0; rx_word = '0;
        ser_start = 1'b0; ser_valid = 1'b0; ser_bit = 1'b0; ser_check = 1'b0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(ser_done == 1'b0, "R10 done", 16'(ser_done), 16'h0);
        check(ser_crc == 4'hF, "R10 crc", 16'(ser_crc), 16'hF);
        check(ser_ok == 1'b1, "R10 ok", 16'(ser_ok), 16'h1);
        rst_n = 1'b1;

        // Table walk: R1, R2, R3 in parallel; R5, R7 over the serial path
        for (int v = 0; v < 8; v++) begin
            gen_payload = VEC[v][27:16];
            rx_word     = VEC[v][15:0];
            #1;
            check(gen_word[15:4] == VEC[v][27:16], "R1 payload", gen_word, {VEC[v][27:16], 4'h0});
            check(gen_word == VEC[v][15:0], "R2 table", gen_word, VEC[v][15:0]);
            check(rx_ok == 1'b1, "R3 table", 16'(rx_ok), 16'h1);
            send_frame(VEC[v][15:0], 1'b1, 1'b0);
            check(ser_done == 1'b1, "R5 done", 16'(ser_done), 16'h1);
            check(ser_ok == 1'b1, "R7 good frame", 16'(ser_ok), 16'h1);
            @(negedge clk);
            check(ser_done == 1'b0, "R5 pulse width", 16'(ser_done), 16'h0);
        end

        // R4: every single-bit flip of good words must fail
        for (int v = 0; v < 8; v++) begin
            gen_payload = VEC[v][27:16];
            for (int b = 0; b < 16; b++) begin
                rx_word = VEC[v][15:0] ^ (16'h1 << b);
                #1;
                check(rx_ok == 1'b0, "R4 flip", 16'(rx_ok), 16'h0);
            end
        end

        // R7: corrupted serial frames fail in check mode
        send_frame(16'hC102 ^ 16'h0100, 1'b1, 1'b0);
        check(ser_done && !ser_ok, "R7 bad frame", 16'(ser_ok), 16'h0);
        send_frame(16'hC103, 1'b1, 1'b0);
        check(ser_done && !ser_ok, "R7 bad crc", 16'(ser_ok), 16'h0);

        // R6, R2, R3: exhaustive, garbage tail bits in generate mode
        for (int p = 0; p < 4096; p++) begin
            gen_payload = 12'(p);
            rx_word     = ref_word(12'(p));
            send_frame({12'(p), 4'b1010}, 1'b0, 1'b0);
            check(ser_done && ser_crc == gen_word[3:0], "R6 serial vs parallel",
                  16'(ser_crc), 16'(gen_word[3:0]));
            check(gen_word == ref_word(12'(p)), "R2 exhaustive", gen_word, ref_word(12'(p)));
            check(rx_ok == 1'b1, "R3 exhaustive", 16'(rx_ok), 16'h1);
        end

        // R8: gaps in the valid strobe do not disturb the result
        send_frame(16'hC102, 1'b1, 1'b1);
        check(ser_done && ser_ok, "R8 gapped check", 16'(ser_ok), 16'h1);
        send_frame(16'hC100, 1'b0, 1'b1);
        check(ser_done && ser_crc == 4'h2, "R8 gapped generate", 16'(ser_crc), 16'h2);

        // R9: extra bits after the frame are ignored
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            ser_valid = 1'b1; ser_bit = k[0];
        end
        @(negedge clk);
        ser_valid = 1'b0;
        check(ser_done == 1'b0, "R9 no done", 16'(ser_done), 16'h0);
        check(ser_crc == 4'h2, "R9 crc held", 16'(ser_crc), 16'h2);

        // R11: a restart in mid-frame discards the partial frame
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            ser_start = (k == 0); ser_valid = 1'b1; ser_bit = 1'b1; ser_check = 1'b1;
        end
        send_frame(16'h003A, 1'b1, 1'b0);
        check(ser_done && ser_ok, "R11 restart", 16'(ser_ok), 16'h1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule